// File: doc/BRIEF.md
# Matrix Keypad Scan Controller

This block scans a key matrix of up to 16 rows by 16 columns. It drives one row at a time, samples the column lines and keeps one 16-bit word per row. Software reaches it through a flat 32-bit register bus with byte addresses. The block holds a control register (scan mode, row settle delay, inter-scan gap), a size register (row and column counts), a write-one-to-clear event register, an event mask and read-only row data words. It drives one interrupt line.

Keys are active low. A pressed key pulls its column low while its row is driven low, and a released column reads 1. The column inputs pass through a two-flop synchronizer before any logic uses them. There are four modes. Idle releases every row. Detect drives every row low and only flags that some key is down. Single scan walks the enabled rows once and then sets the mode field back to idle. Continuous scan repeats the walk, with a programmable gap between passes.

Top module: `kpd_scanner`

## Requirements
- R1: After reset the control, size, event and mask registers read 0, every row data word reads 0xFFFF, `irq_o` is 0 and every row output is 1.
- R2: With mode field (control bits 1:0) equal to 0, every bit of `row_n_o` is 1 and no row data word changes.
- R3: In modes 2 (single) and 3 (continuous), at most one row output is 0 at a time. Rows are visited in ascending order from row 0, and each row is held for row-wait + 1 cycles before it is sampled. Row-wait is control bits 15:2.
- R4: When a mode 2 pass ends, the mode field reads 0 and event bit 0 (pass complete) is set.
- R5: In mode 3, a new pass begins inner-gap + 1 cycles after the previous pass ends, with no software action. Inner-gap is control bits 31:16, and the mode field stays 3.
- R6: In mode 1 (detect) every row output is 0 and no row data word is written. Event bit 2 is set in every cycle in which any synchronized column is low, so a clear of bit 2 has no effect while a key is held.
- R7: Size bits 7:0 give the row count N. Rows with index N or above are not sampled and keep their previous words.
- R8: Size bits 15:8 give the column count C. In every row that is written, bits with index C or above are stored as 1, and bit c below C is 0 exactly when key (row, c) is pressed.
- R9: Event bit 1 is set when a sampled row word differs from the stored word. A pass with no difference leaves it clear.
- R10: A write to the event register at byte 0x08 clears each bit written as 1 and leaves the others alone. An event raised in the same cycle wins.
- R11: `irq_o` is 1 exactly when some event bit and the same bit of the mask register (byte 0x0C) are both 1.
- R12: A write of the control register stops any pass in progress, and a pass stopped this way does not set event bit 0.
- R13: Row r is read from byte 0x10 + 4*(r/2), in bits 15:0 for even r and bits 31:16 for odd r. The control register sits at byte 0x00 and the size register at byte 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address, bits 1:0 ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| row_n_o | output | 16 | Row drives, 0 = driven low |
| col_ni | input | 16 | Column lines, 0 = key contact |
| irq_o | output | 1 | Masked event interrupt |

## Verification
On every cycle the assertions check the following. Idle releases all rows. Scan modes never drive more than one row. Detect mode never samples. A held key keeps the detect event set. Sampling stays inside the row count. The single-scan mode field returns to idle after its pass. Event clears take effect. A control write suppresses the pass-complete event. Some behaviours need the bench's scenarios: the stored column values under different column counts, stale rows beyond the row count, the data-changed event across repeated passes, continuous rescanning after a key changes, and an aborted long pass that never completes.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_DETECT = 2'd1,
    M_SINGLE = 2'd2,
    M_CONT   = 2'd3
  } kpd_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETTLE,
    S_GAP
  } kpd_state_e;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_SIZE = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_MASK = 8'h0C;
  localparam logic [7:0] A_DATA = 8'h10;
  localparam logic [7:0] A_DEND = 8'h30;

  localparam int unsigned N_EVT   = 3;
  localparam int unsigned EV_DONE = 0;
  localparam int unsigned EV_CHG  = 1;
  localparam int unsigned EV_KEY  = 2;
  localparam int unsigned HW      = 16;
endpackage

// File: rtl/kpd_col_sync.sv
module kpd_col_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/kpd_scan_fsm.sv
module kpd_scan_fsm
  import kpd_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  localparam int unsigned RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  kpd_mode_e       mode_i,
  input  logic [13:0]     row_wait_i,
  input  logic [15:0]     scan_gap_i,
  input  logic [7:0]      nrows_i,
  output logic [ROWS-1:0] row_n_o,
  output logic            sample_o,
  output logic [RIW-1:0]  row_idx_o,
  output logic            scan_done_o
);
  kpd_state_e     state_q;
  logic [15:0]    cnt_q;
  logic [RIW-1:0] row_q;
  logic [8:0]     eff_rows;
  logic           scan_mode, empty, last_row, begin_scan;

  always_comb begin
    eff_rows   = ({1'b0, nrows_i} > 9'(ROWS)) ? 9'(ROWS) : {1'b0, nrows_i};
    scan_mode  = (mode_i == M_SINGLE) || (mode_i == M_CONT);
    empty      = (eff_rows == 9'd0);
    last_row   = (9'(row_q) + 9'd1) >= eff_rows;
    begin_scan = scan_mode && !restart_i &&
                 ((state_q == S_IDLE) || (state_q == S_GAP && cnt_q == 16'd0));
    sample_o   = scan_mode && !restart_i && (state_q == S_SETTLE) && (cnt_q == 16'd0);
    scan_done_o = (sample_o && last_row) || (begin_scan && empty);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else if (restart_i || !scan_mode) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else if (begin_scan) begin
      row_q <= '0;
      if (empty) begin
        state_q <= (mode_i == M_CONT) ? S_GAP : S_IDLE;
        cnt_q   <= scan_gap_i;
      end else begin
        state_q <= S_SETTLE;
        cnt_q   <= {2'b00, row_wait_i};
      end
    end else if (cnt_q != 16'd0) begin
      cnt_q <= cnt_q - 16'd1;
    end else if (state_q == S_SETTLE) begin
      if (last_row) begin
        row_q   <= '0;
        state_q <= (mode_i == M_CONT) ? S_GAP : S_IDLE;
        cnt_q   <= scan_gap_i;
      end else begin
        row_q <= row_q + RIW'(1);
        cnt_q <= {2'b00, row_wait_i};
      end
    end
  end

  always_comb begin
    row_n_o = '1;
    if (mode_i == M_DETECT) row_n_o = '0;
    else if (state_q == S_SETTLE) row_n_o[row_q] = 1'b0;
  end

  assign row_idx_o = row_q;

  a_r7_sample_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (9'(row_q) < eff_rows));
endmodule

// File: rtl/kpd_row_store.sv
module kpd_row_store
  import kpd_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [RIW-1:0]   row_i,
  input  logic [COLS-1:0]  cols_i,
  input  logic [7:0]       ncols_i,
  output logic             changed_o,
  output logic [ROWS*HW-1:0] data_o
);
  logic [HW-1:0] mem_q [ROWS];
  logic [HW-1:0] word;

  for (genvar c = 0; c < HW; c++) begin : g_col
    if (c < COLS) begin : g_live
      assign word[c] = (8'(c) >= ncols_i) ? 1'b1 : cols_i[c];
    end else begin : g_pad
      assign word[c] = 1'b1;
    end
  end

  assign changed_o = wr_i && (word != mem_q[row_i]);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem_q[r] <= '1;
      else if (wr_i && row_i == RIW'(r))  mem_q[r] <= word;
    end
    assign data_o[r*HW +: HW] = mem_q[r];
  end

  a_r8_pad_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ncols_i == 8'd0) |=> (mem_q[$past(row_i)] == '1));
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
  import kpd_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_sel_i,
  input  logic            bus_we_i,
  input  logic [7:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic [ROWS-1:0] row_n_o,
  input  logic [COLS-1:0] col_ni,
  output logic            irq_o
);
  logic [31:0]      ctrl_q;
  logic [15:0]      size_q;
  logic [N_EVT-1:0] stat_q, mask_q, evt_set;
  kpd_mode_e        mode_q;
  logic             ctrl_wr, size_wr, stat_wr, mask_wr;
  logic [COLS-1:0]  col_s;
  logic             sample, scan_done, changed, key_any;
  logic [RIW-1:0]   row_idx;
  logic [ROWS*HW-1:0] row_data;

  assign mode_q  = kpd_mode_e'(ctrl_q[1:0]);
  assign ctrl_wr = bus_sel_i && bus_we_i && (bus_addr_i[7:2] == A_CTRL[7:2]);
  assign size_wr = bus_sel_i && bus_we_i && (bus_addr_i[7:2] == A_SIZE[7:2]);
  assign stat_wr = bus_sel_i && bus_we_i && (bus_addr_i[7:2] == A_STAT[7:2]);
  assign mask_wr = bus_sel_i && bus_we_i && (bus_addr_i[7:2] == A_MASK[7:2]);

  kpd_col_sync #(.W(COLS)) u_sync (
    .clk_i, .rst_ni, .d_i(col_ni), .q_o(col_s)
  );

  kpd_scan_fsm #(.ROWS(ROWS)) u_fsm (
    .clk_i, .rst_ni,
    .restart_i   (ctrl_wr),
    .mode_i      (mode_q),
    .row_wait_i  (ctrl_q[15:2]),
    .scan_gap_i  (ctrl_q[31:16]),
    .nrows_i     (size_q[7:0]),
    .row_n_o     (row_n_o),
    .sample_o    (sample),
    .row_idx_o   (row_idx),
    .scan_done_o (scan_done)
  );

  kpd_row_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk_i, .rst_ni,
    .wr_i      (sample),
    .row_i     (row_idx),
    .cols_i    (col_s),
    .ncols_i   (size_q[15:8]),
    .changed_o (changed),
    .data_o    (row_data)
  );

  assign key_any = (mode_q == M_DETECT) && !(&col_s);

  always_comb begin
    evt_set          = '0;
    evt_set[EV_DONE] = scan_done;
    evt_set[EV_CHG]  = changed;
    evt_set[EV_KEY]  = key_any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      size_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata_i;
      else if (scan_done && mode_q == M_SINGLE) ctrl_q[1:0] <= M_IDLE;
      if (size_wr) size_q <= bus_wdata_i[15:0];
      if (mask_wr) mask_q <= bus_wdata_i[N_EVT-1:0];
      stat_q <= (stat_wr ? (stat_q & ~bus_wdata_i[N_EVT-1:0]) : stat_q) | evt_set;
    end
  end

  assign irq_o = |(stat_q & mask_q);

  function automatic logic [HW-1:0] row_word(input logic [3:0] idx);
    if (int'(idx) < ROWS) return row_data[int'(idx)*HW +: HW];
    return '1;
  endfunction

  logic [7:0] doff;
  assign doff = bus_addr_i - A_DATA;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i >= A_DATA && bus_addr_i < A_DEND)
      bus_rdata_o = {row_word({doff[4:2], 1'b1}), row_word({doff[4:2], 1'b0})};
    else case (bus_addr_i[7:2])
      A_CTRL[7:2]: bus_rdata_o = ctrl_q;
      A_SIZE[7:2]: bus_rdata_o = {16'h0, size_q};
      A_STAT[7:2]: bus_rdata_o = {{(32-N_EVT){1'b0}}, stat_q};
      A_MASK[7:2]: bus_rdata_o = {{(32-N_EVT){1'b0}}, mask_q};
      default:     bus_rdata_o = '0;
    endcase
  end

  a_r2_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_IDLE) |-> (&row_n_o));
  a_r3_one_row_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SINGLE || mode_q == M_CONT) |-> ($countones(~row_n_o) <= 1));
  a_r4_single_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_done && mode_q == M_SINGLE && !ctrl_wr) |=> (mode_q == M_IDLE));
  a_r6_detect_no_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DETECT) |-> !sample);
  a_r6_key_holds_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DETECT && !(&col_s)) |=> stat_q[EV_KEY]);
  a_r10_clear_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && bus_wdata_i[EV_DONE] && !scan_done) |=> !stat_q[EV_DONE]);
  a_r12_no_done_after_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !scan_done);
  a_r11_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|mask_q));
endmodule

// File: tb/tb_kpd_scanner.sv
module tb_kpd_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] row_n, col_n;
  logic        irq;
  logic [15:0] keys [16];
  int          n_chk = 0, n_err = 0, cyc = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  kpd_scanner dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .row_n_o(row_n), .col_ni(col_n), .irq_o(irq)
  );

  always_comb begin
    col_n = '1;
    for (int r = 0; r < 16; r++) if (!row_n[r]) col_n = col_n & ~keys[r];
  end

  // {row, pressed keys, column count, expected word}
  localparam logic [43:0] VECS [6] = '{
    {4'd0,  16'h0001, 8'd16, 16'hFFFE},
    {4'd5,  16'h8001, 8'd16, 16'h7FFE},
    {4'd15, 16'hFFFF, 8'd8,  16'hFF00},
    {4'd3,  16'h00F0, 8'd4,  16'hFFFF},
    {4'd9,  16'h0000, 8'd16, 16'hFFFF},
    {4'd10, 16'h1234, 8'd12, 16'hFDCB}
  };

  localparam logic [31:0] CTRL_SINGLE = 32'h2 | (32'd3 << 2);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_row(input int r, output logic [15:0] d);
    logic [31:0] w;
    rd(8'h10 + 8'((r / 2) * 4), w);
    d = (r % 2 == 1) ? w[31:16] : w[15:0];
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h08, s);
      if (s[0]) break;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 16; r++) keys[r] = '0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_err++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] h;
    clear_keys();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset state
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h04, v); check("R1 size", v, 32'h0);
    rd(8'h08, v); check("R1 stat", v, 32'h0);
    rd(8'h0C, v); check("R1 mask", v, 32'h0);
    rd(8'h2C, v); check("R1 data", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R2 rows released", {16'h0, row_n}, 32'h0000_FFFF);

    // R8 / R13 / R4 vector walk
    foreach (VECS[i]) begin
      clear_keys();
      keys[VECS[i][43:40]] = VECS[i][39:24];
      wr(8'h04, {16'h0, VECS[i][23:16], 8'd16});
      wr(8'h00, CTRL_SINGLE);
      wait_done();
      rd_row(int'(VECS[i][43:40]), h);
      check("R8 row word", {16'h0, h}, {16'h0, VECS[i][15:0]});
      rd(8'h00, v); check("R4 mode idle", {30'h0, v[1:0]}, 32'h0);
      rd(8'h08, v); check("R4 done set", {31'h0, v[0]}, 32'h1);
      wr(8'h08, 32'h7);
    end

    // R9 / R10 change event and clearing
    clear_keys();
    wr(8'h04, 32'h1010);
    wr(8'h00, CTRL_SINGLE);
    wait_done();
    rd(8'h08, v); check("R9 changed", v, 32'h3);
    wr(8'h08, 32'h1);
    rd(8'h08, v); check("R10 clear bit0 only", v, 32'h2);
    wr(8'h08, 32'h2);
    rd(8'h08, v); check("R10 clear bit1", v, 32'h0);
    wr(8'h00, CTRL_SINGLE);
    wait_done();
    rd(8'h08, v); check("R9 no change", v, 32'h1);

    // R11 mask
    wr(8'h0C, 32'h1);
    #2 check("R11 irq on", {31'h0, irq}, 32'h1);
    wr(8'h0C, 32'h2);
    #2 check("R11 irq masked", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h7);
    wr(8'h0C, 32'h0);

    // R7 row count
    keys[6] = 16'h0001;
    keys[2] = 16'h0002;
    wr(8'h04, 32'h1004);
    wr(8'h00, CTRL_SINGLE);
    wait_done();
    rd_row(2, h); check("R7 row in range", {16'h0, h}, 32'h0000_FFFD);
    rd_row(6, h); check("R7 row stale", {16'h0, h}, 32'h0000_FFFF);
    wr(8'h08, 32'h7);

    // R6 detect
    clear_keys();
    keys[12] = 16'h0008;
    wr(8'h04, 32'h1010);
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    check("R6 rows driven", {16'h0, row_n}, 32'h0);
    rd(8'h08, v); check("R6 key event", v, 32'h4);
    wr(8'h08, 32'h4);
    rd(8'h08, v); check("R6 clear ignored while held", v, 32'h4);
    clear_keys();
    repeat (5) @(negedge clk);
    wr(8'h08, 32'h4);
    rd(8'h08, v); check("R6 clear after release", v, 32'h0);
    rd_row(12, h); check("R6 data untouched", {16'h0, h}, 32'h0000_FFFF);
    rd_row(2, h); check("R6 data kept", {16'h0, h}, 32'h0000_FFFD);

    // R2 idle leaves data
    keys[2] = 16'h0000;
    wr(8'h00, 32'h0);
    repeat (50) @(negedge clk);
    rd_row(2, h); check("R2 idle no write", {16'h0, h}, 32'h0000_FFFD);

    // R5 continuous
    keys[1] = 16'h0100;
    wr(8'h08, 32'h7);
    wr(8'h00, 32'h3 | (32'd3 << 2) | (32'd20 << 16));
    wait_done();
    rd_row(1, h); check("R5 first pass", {16'h0, h}, 32'h0000_FEFF);
    keys[1] = 16'h0200;
    wr(8'h08, 32'h7);
    wait_done();
    wr(8'h08, 32'h7);
    wait_done();
    rd_row(1, h); check("R5 rescanned", {16'h0, h}, 32'h0000_FDFF);
    rd(8'h00, v); check("R5 mode kept", {30'h0, v[1:0]}, 32'h3);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h7);

    // R12 abort, R3 single row driven
    clear_keys();
    wr(8'h00, 32'h2 | (32'd1000 << 2));
    repeat (100) @(negedge clk);
    check("R3 row0 driven", {16'h0, row_n}, 32'h0000_FFFE);
    wr(8'h00, 32'h0);
    repeat (17000) @(negedge clk);
    rd(8'h08, v); check("R12 no done", v, 32'h0);
    check("R12 rows released", {16'h0, row_n}, 32'h0000_FFFF);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule